// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower memory port. It holds eight one-word lines. Each word address is split into a line index, taken from its low three bits, and a tag, taken from the remaining upper bits. Each line keeps a valid flag, the tag and the data word. A read that hits returns its word combinationally in the cycle it is presented. A read that misses stalls the processor while the word is fetched from memory and written into its line. The access then completes from the cache.

Every write is sent to memory through a four-entry FIFO, which drains one entry per memory handshake. The processor is held only when that FIFO is full. A write that hits also updates the cached word. A write that misses leaves the cache untouched and fetches nothing. A read miss is not issued until the FIFO has drained, so a read can never overtake an older write. The memory port uses a valid/ready request handshake and returns read data on a separate valid strobe after any number of cycles.

Top module: `wt_cache`

## Requirements
- R1: After reset, and again after any later reset, every line is invalid. With no request, `cpu_stall_o` and `mem_req_o` are both 0.
- R2: A read hits only if the line at index `addr[2:0]` is valid and its stored tag equals `addr[ADDR_W-1:3]`. Reading the word addresses 22, 26, 22, 26, 16, 3, 16, 18 from reset gives miss, miss, hit, hit, miss, miss, hit, miss.
- R3: A read hit keeps `cpu_stall_o` at 0 and drives the line's word on `cpu_rdata_o` in the same cycle.
- R4: A read miss with an empty write FIFO and memory always ready holds `cpu_stall_o` high for exactly L+2 cycles, where L is the number of cycles from the read request handshake to `mem_rvalid_i`. The access then completes with the memory word.
- R5: A fill replaces whatever the line held before. After 18 fills index 2, a read of 26 misses.
- R6: A write hit is accepted without a stall and updates the cached word, so the next read hits with the new value. It also reaches memory, and it issues no memory read.
- R7: A write miss is sent to memory without a line fetch and without allocating. The line at its index keeps its old contents, and a later read of the written address misses and returns the new value.
- R8: Writes are accepted without a stall while fewer than 4 are waiting. A write arriving with 4 waiting is stalled until one drains.
- R9: Waiting writes reach memory one per handshake, oldest first.
- R10: A read miss issues no memory read while any write is waiting. A read of an address just written therefore returns the written value.
- R11: A memory request that is not yet granted keeps its request, direction and address unchanged until `mem_ready_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor access request, held while stalled |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Read data, valid when a read is not stalled |
| cpu_stall_o | output | 1 | Access not completed this cycle |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data from memory |

## Verification
A read hit or an accepted write shows `cpu_stall_o` low in the same cycle the request is driven. A read miss completes L+2 cycles later, counted from the request: one cycle to register the miss, one for the handshake, and L for the memory response. The bench drives each request just after a falling edge and samples the stall one time unit later. It then counts the stalled cycles up to the first cycle without a stall, and reads the data in that cycle, before the edge that retires the access. The memory model acts two time units after each falling edge, so handshakes and responses are settled before the next rising edge.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_WAIT = 2'd2
  } cache_st_e;
endpackage

// File: rtl/wt_cache_lines.sv
module wt_cache_lines #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              upd_en_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic              fill_en_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;

  assign lk_idx   = lk_addr_i[IDX_W-1:0];
  assign lk_tag   = lk_addr_i[ADDR_W-1:IDX_W];
  assign fill_idx = fill_addr_i[IDX_W-1:0];
  assign fill_tag = fill_addr_i[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     valid_q[g] <= 1'b0;
      else if (fill_en_i && fill_idx == IDX_W'(g))     valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (fill_en_i && fill_idx == IDX_W'(g)) begin
        tag_q[g]  <= fill_tag;
        data_q[g] <= fill_data_i;
      end else if (upd_en_i && lk_idx == IDX_W'(g)) begin
        data_q[g] <= upd_data_i;
      end
    end
  end

  assign hit_o  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign data_o = data_q[lk_idx];

  // R2
  fill_then_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> (lk_addr_i != $past(fill_addr_i)) || hit_o);

  // R7
  upd_only_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |-> hit_o);
endmodule

// File: rtl/wt_cache_wbuf.sv
module wt_cache_wbuf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LINES   = 8,
  parameter int WB_SIZE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  cache_st_e         state_q;
  logic [ADDR_W-1:0] miss_addr_q;

  logic              hit, rd_hit, push, pop, fill_en, rd_phase;
  logic              wb_empty, wb_full;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;

  wt_cache_lines #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_lines (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_addr_i   (cpu_addr_i),
    .upd_en_i    (push && hit),
    .upd_data_i  (cpu_wdata_i),
    .fill_en_i   (fill_en),
    .fill_addr_i (miss_addr_q),
    .fill_data_i (mem_rdata_i),
    .hit_o       (hit),
    .data_o      (cpu_rdata_o)
  );

  wt_cache_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_SIZE)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (cpu_addr_i),
    .push_data_i (cpu_wdata_i),
    .pop_i       (pop),
    .head_addr_o (wb_addr),
    .head_data_o (wb_data),
    .empty_o     (wb_empty),
    .full_o      (wb_full)
  );

  assign rd_hit      = (state_q == ST_IDLE) && cpu_req_i && !cpu_we_i && hit;
  assign push        = (state_q == ST_IDLE) && cpu_req_i && cpu_we_i && !wb_full;
  assign cpu_stall_o = cpu_req_i && !(rd_hit || push);
  assign fill_en     = (state_q == ST_RD_WAIT) && mem_rvalid_i;

  // read fetch owns the port only once the buffer is empty
  assign rd_phase    = (state_q == ST_RD_REQ);
  assign mem_req_o   = rd_phase || !wb_empty;
  assign mem_we_o    = !rd_phase;
  assign mem_addr_o  = rd_phase ? miss_addr_q : wb_addr;
  assign mem_wdata_o = wb_data;
  assign pop         = !rd_phase && !wb_empty && mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      miss_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cpu_req_i && !cpu_we_i && !hit && wb_empty) begin
          state_q     <= ST_RD_REQ;
          miss_addr_q <= cpu_addr_i;
        end
        ST_RD_REQ:  if (mem_ready_i)  state_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rvalid_i) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  fill_completes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |=> !cpu_req_i || cpu_we_i || (cpu_addr_i != $past(miss_addr_q)) || !cpu_stall_o);

  // R10
  read_after_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty);

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));
endmodule

// File: tb/wt_cache_test.sv
module wt_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int SEQ_ADDR [8] = '{22, 26, 22, 26, 16, 3, 16, 18};
  localparam bit SEQ_HIT  [8] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_req_i = 1'b0, cpu_we_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [DW-1:0] cpu_wdata_i = '0;
  logic [DW-1:0] cpu_rdata_o;
  logic          cpu_stall_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ready_i;
  logic          mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  wt_cache #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o), .cpu_stall_o(cpu_stall_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model, acting two time units after each falling edge
  logic [DW-1:0] mem_model [256];
  logic [DW-1:0] ref_mem   [256];
  logic [AW-1:0] wlog      [32];
  logic [AW-1:0] rd_addr_q = '0;
  int  rd_cnt = 0, wr_cnt = 0, lat_cnt = 0, mem_lat = 1;
  bit  ready_en = 1'b1;
  assign mem_ready_i = ready_en;

  always @(negedge clk) begin
    #2;
    mem_rvalid_i = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_model[rd_addr_q];
      end
    end
    if (rst_ni && mem_req_o && mem_ready_i) begin
      if (mem_we_o) begin
        mem_model[mem_addr_o] = mem_wdata_o;
        if (wr_cnt < 32) wlog[wr_cnt] = mem_addr_o;
        wr_cnt++;
      end else begin
        rd_cnt++;
        rd_addr_q = mem_addr_o;
        lat_cnt   = mem_lat;
      end
    end
  end

  task automatic access(input bit we, input int addr, input logic [DW-1:0] wd,
                        output bit first_stall, output int stalls, output logic [DW-1:0] rd);
    @(negedge clk);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = addr[AW-1:0]; cpu_wdata_i = wd;
    #1;
    first_stall = cpu_stall_o;
    stalls = 0;
    while (cpu_stall_o && stalls < 500) begin
      stalls++;
      @(negedge clk); #1;
    end
    rd = cpu_rdata_o;
    if (we) ref_mem[addr] = wd;
    @(posedge clk); #1;
    cpu_req_i = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); #1;
      if (!mem_req_o) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit fs;
    int ns;
    logic [DW-1:0] rd;
    int w0, rc;

    for (int i = 0; i < 256; i++) begin
      mem_model[i] = 32'hC0DE_0000 | i;
      ref_mem[i]   = 32'hC0DE_0000 | i;
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 stall in reset", cpu_stall_o, 0);
    chk("R1 mem_req in reset", mem_req_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 stall idle", cpu_stall_o, 0);
    chk("R1 mem_req idle", mem_req_o, 0);

    // R2 R3 R4 table walk
    for (int i = 0; i < 8; i++) begin
      access(1'b0, SEQ_ADDR[i], '0, fs, ns, rd);
      chk($sformatf("R2 hit/miss step %0d", i), fs, !SEQ_HIT[i]);
      chk($sformatf("R3 R4 data step %0d", i), rd, ref_mem[SEQ_ADDR[i]]);
      if (!SEQ_HIT[i]) chk($sformatf("R4 stall cycles step %0d", i), ns, mem_lat + 2);
    end

    // R5 26 was evicted by 18
    access(1'b0, 26, '0, fs, ns, rd);
    chk("R5 replaced line misses", fs, 1);
    chk("R5 data", rd, ref_mem[26]);

    // R4 longer latency
    mem_lat = 4;
    access(1'b0, 5, '0, fs, ns, rd);
    chk("R4 stall cycles lat4", ns, 6);
    chk("R4 data lat4", rd, ref_mem[5]);
    mem_lat = 1;

    // R6 write hit
    rc = rd_cnt;
    access(1'b1, 16, 32'h1234_5678, fs, ns, rd);
    chk("R6 write hit no stall", fs, 0);
    drain();
    access(1'b0, 16, '0, fs, ns, rd);
    chk("R6 read after write hits", fs, 0);
    chk("R6 updated data", rd, 32'h1234_5678);
    chk("R6 memory updated", mem_model[16], 32'h1234_5678);
    chk("R6 no memory read", rd_cnt, rc);

    // R7 write miss, index 3 holds address 3
    rc = rd_cnt;
    access(1'b1, 11, 32'hBEEF_0011, fs, ns, rd);
    chk("R7 write miss no stall", fs, 0);
    drain();
    chk("R7 no fetch", rd_cnt, rc);
    chk("R7 memory written", mem_model[11], 32'hBEEF_0011);
    access(1'b0, 3, '0, fs, ns, rd);
    chk("R7 old line still hits", fs, 0);
    chk("R7 old line data", rd, ref_mem[3]);
    access(1'b0, 11, '0, fs, ns, rd);
    chk("R7 not allocated", fs, 1);
    chk("R7 read data", rd, 32'hBEEF_0011);

    // R8 R9 full buffer
    ready_en = 1'b0;
    w0 = wr_cnt;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 40 + i, 32'hAB00_0000 | i, fs, ns, rd);
      chk($sformatf("R8 write %0d accepted", i), fs, 0);
    end
    fork
      access(1'b1, 44, 32'hAB00_0004, fs, ns, rd);
      begin repeat (4) @(negedge clk); ready_en = 1'b1; end
    join
    chk("R8 fifth write stalls", fs, 1);
    drain();
    chk("R9 write count", wr_cnt - w0, 5);
    for (int i = 0; i < 5; i++)
      chk($sformatf("R9 drain order %0d", i), wlog[w0 + i], 40 + i);

    // R10 read waits for pending write
    ready_en = 1'b0;
    access(1'b1, 50, 32'h5050_5050, fs, ns, rd);
    fork
      access(1'b0, 50, '0, fs, ns, rd);
      begin repeat (3) @(negedge clk); ready_en = 1'b1; end
    join
    chk("R10 read miss", fs, 1);
    chk("R10 read sees write", rd, 32'h5050_5050);

    // R11 request held while not granted
    ready_en = 1'b0;
    fork
      access(1'b0, 7, '0, fs, ns, rd);
      begin
        repeat (3) @(negedge clk); #1;
        chk("R11 req held", mem_req_o, 1);
        chk("R11 read dir held", mem_we_o, 0);
        chk("R11 addr held", mem_addr_o, 7);
        ready_en = 1'b1;
      end
    join
    chk("R11 data", rd, ref_mem[7]);

    // R1 reset mid-run invalidates
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    access(1'b0, 22, '0, fs, ns, rd);
    chk("R1 invalid after reset", fs, 1);
    chk("R1 data after reset", rd, ref_mem[22]);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule